// File: doc/BRIEF.md
# PLL Phase-Step Sequencer

This block moves the phase of one PLL output clock by a requested number of fine steps. A caller gives it a start pulse, a counter select and a signed step count. The block then runs the step handshake with the PLL once for each step. It raises a step strobe, holds a direction bit and a counter-select field steady, and waits for the PLL's done line to fall and then return high before it starts the next step.

Everything runs on the scan clock. The PLL latches the strobe on a falling edge, then captures direction and select on the second rising edge after that. It pulls done low on that same edge and keeps it low for a time the block does not know in advance. All outputs change only on rising edges. The strobe therefore settles half a cycle before the PLL samples it, and direction and select settle at least one cycle before they are captured.

The block keeps a signed running total of the steps applied to each counter. It shows busy while a request is in progress, gives a one-cycle finish pulse at the end, and sets a sticky error flag when it gives up on a PLL that does not respond.

Top module: `phase_step_ctrl`

## Requirements
- R1: After reset, `pll_step`, `busy`, `finish` and `err` are low, `pll_done` is treated as idle-high, and every running total is zero.
- R2: A start while idle with a nonzero count is accepted. `req_steps` is a 9-bit two's-complement value. The block produces exactly |count| strobe pulses on the counter given by `req_sel`. `pll_dir` is 1 (delay added) for a positive count and 0 for a negative one.
- R3: Each strobe pulse stays high for at least two cycles and until `pll_done` has been sampled low. It drops on the first rising edge at which both conditions hold.
- R4: `pll_dir` and `pll_sel` do not change while `pll_step` is high.
- R5: The strobe rises only on an edge at which `pll_done` is sampled high. Between two pulses the strobe is low for at least one cycle.
- R6: `totals` holds one signed 16-bit two's-complement total per counter, with counter i at bits [16*i+15:16*i]. A total changes by +1 (up) or -1 (down) on the edge where `pll_done` is seen high again after a step.
- R7: `busy` rises on the edge that accepts a start. It falls on the edge that sees the final done rise, and `finish` is high for exactly that one cycle.
- R8: A start while busy, or a start with a count of zero, is ignored. No strobe is issued and no total changes.
- R9: If `pll_done` has not fallen by the 8th edge after the strobe rose, the block aborts on that edge. It drops the strobe, clears `busy` and sets `err`.
- R10: If `pll_done` stays low for 1024 edges, the block aborts and sets `err`. This applies while the block waits for done to return after a step, and while it waits for done to be high before a request's first step. The step that is left incomplete is not added to any total.
- R11: `err` stays high until the next accepted start, and that start clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request pulse |
| req_sel | input | 4 | Counter to be stepped |
| req_steps | input | 9 | Signed step count, two's complement |
| busy | output | 1 | Request in progress |
| finish | output | 1 | One-cycle pulse when the last step completes |
| err | output | 1 | Sticky timeout flag |
| pll_step | output | 1 | Step strobe to the PLL |
| pll_dir | output | 1 | Step direction, 1 = up |
| pll_sel | output | 4 | Counter select to the PLL |
| pll_done | input | 1 | Phase-shift done from the PLL, low while a step is in progress |
| totals | output | 256 | Per-counter signed running totals, 16 bits each |

## Verification
A PLL model answers each strobe with a done-low time drawn at random from one cycle to many cycles. If a design assumed a fixed done-low time, it would drop the strobe too early or start the next step while done is still low, and the model would then miscount the steps. The bench runs full-magnitude requests in both directions and a single step with long done-low times. A wrong sign decode or an off-by-one in the step count shows up as a mismatch in the totals or in the pulse count. It also issues a start while busy and a start with a zero count. A design that queued or acted on either would show extra strobes or a changed total. Two stalled PLL cases are timed edge by edge from the strobe rising or falling to the error flag. This catches a timeout limit that is off by one, or a step from the aborted attempt that gets counted.

// File: rtl/phase_step_ctrl.sv
module phase_step_ctrl #(
  parameter int SEL_W    = 4,
  parameter int CNT_W    = 9,
  parameter int ACC_W    = 16,
  parameter int MIN_HOLD = 2,
  parameter int TO_FALL  = 8,
  parameter int TO_RISE  = 1024
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic [SEL_W-1:0]                req_sel,
  input  logic [CNT_W-1:0]                req_steps,
  output logic                            busy,
  output logic                            finish,
  output logic                            err,
  output logic                            pll_step,
  output logic                            pll_dir,
  output logic [SEL_W-1:0]                pll_sel,
  input  logic                            pll_done,
  output logic [(1<<SEL_W)*ACC_W-1:0]     totals
);

  localparam int NUM_CNT = 1 << SEL_W;
  localparam int TMR_W   = $clog2(TO_RISE + 1);
  localparam logic [TMR_W-1:0] HOLD_LIM = TMR_W'(MIN_HOLD - 1);
  localparam logic [TMR_W-1:0] FALL_LIM = TMR_W'(TO_FALL - 1);
  localparam logic [TMR_W-1:0] RISE_LIM = TMR_W'(TO_RISE - 1);

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_HOLD, S_WAIT} state_t;

  state_t           st;
  logic [CNT_W-1:0] left;
  logic [CNT_W-1:0] mag;
  logic [TMR_W-1:0] tmr;
  logic [ACC_W-1:0] acc [NUM_CNT];
  logic             last;
  logic [ACC_W-1:0] delta;

  assign mag   = req_steps[CNT_W-1] ? (~req_steps + 1'b1) : req_steps;
  assign last  = (left == CNT_W'(1));
  assign delta = pll_dir ? ACC_W'(1) : {ACC_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      left     <= '0;
      tmr      <= '0;
      busy     <= 1'b0;
      finish   <= 1'b0;
      err      <= 1'b0;
      pll_step <= 1'b0;
      pll_dir  <= 1'b0;
      pll_sel  <= '0;
      for (int i = 0; i < NUM_CNT; i++) acc[i] <= '0;
    end else begin
      finish <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start && req_steps != '0) begin
            pll_sel <= req_sel;
            pll_dir <= ~req_steps[CNT_W-1];
            left    <= mag;
            busy    <= 1'b1;
            err     <= 1'b0;
            tmr     <= '0;
            st      <= S_ARM;
          end
        end
        S_ARM: begin
          if (pll_done) begin
            pll_step <= 1'b1;
            tmr      <= '0;
            st       <= S_HOLD;
          end else if (tmr == RISE_LIM) begin
            busy <= 1'b0;
            err  <= 1'b1;
            st   <= S_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_HOLD: begin
          if (!pll_done && tmr >= HOLD_LIM) begin
            pll_step <= 1'b0;
            tmr      <= '0;
            st       <= S_WAIT;
          end else if (pll_done && tmr == FALL_LIM) begin
            pll_step <= 1'b0;
            busy     <= 1'b0;
            err      <= 1'b1;
            st       <= S_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_WAIT: begin
          if (pll_done) begin
            acc[pll_sel] <= acc[pll_sel] + delta;
            left         <= left - 1'b1;
            tmr          <= '0;
            if (last) begin
              busy   <= 1'b0;
              finish <= 1'b1;
              st     <= S_IDLE;
            end else begin
              pll_step <= 1'b1;
              st       <= S_HOLD;
            end
          end else if (tmr == RISE_LIM) begin
            busy <= 1'b0;
            err  <= 1'b1;
            st   <= S_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_tot
    assign totals[g*ACC_W +: ACC_W] = acc[g];
  end

endmodule

// File: rtl/phase_step_ctrl_chk.sv
module phase_step_ctrl_chk #(
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step,
  input logic             dir,
  input logic [SEL_W-1:0] sel,
  input logic             done,
  input logic             busy,
  input logic             finish,
  input logic             err
);

  p_drop_after_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(step) |-> (!$past(done) || err));

  p_min_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(step) |=> step);

  p_fields_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && $past(step)) |-> ($stable(dir) && $stable(sel)));

  p_rearm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(step) |-> $past(done));

  p_busy_cover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> busy);

  p_finish_r7: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> (!busy && $past(busy)));

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (!busy && !step));

endmodule

bind phase_step_ctrl phase_step_ctrl_chk #(.SEL_W(SEL_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .step   (pll_step),
  .dir    (pll_dir),
  .sel    (pll_sel),
  .done   (pll_done),
  .busy   (busy),
  .finish (finish),
  .err    (err)
);

// File: tb/phase_step_ctrl_tb_top.sv
module phase_step_ctrl_tb_top;
  localparam int NUM = 16;
  localparam int AW  = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n;
  logic           start;
  logic [3:0]     req_sel;
  logic [8:0]     req_steps;
  logic           busy, finish, err;
  logic           pll_step, pll_dir;
  logic [3:0]     pll_sel;
  logic           pll_done;
  logic [NUM*AW-1:0] totals;

  phase_step_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .req_sel(req_sel),
    .req_steps(req_steps), .busy(busy), .finish(finish), .err(err),
    .pll_step(pll_step), .pll_dir(pll_dir), .pll_sel(pll_sel),
    .pll_done(pll_done), .totals(totals)
  );

  int vec = 0, miss = 0;
  int exp_tot [NUM] = '{default: 0};

  // PLL model: 0 normal, 1 done never falls, 2 done never rises, 3 release done
  int rmode = 0, rs = 0, low_left = 0, lmax = 3, rpulses = 0;
  int net [NUM] = '{default: 0};
  logic stf = 1'b0, dirf = 1'b0, cap_dir = 1'b0;
  logic [3:0] self = '0, cap_sel = '0;

  always @(negedge clk) begin
    stf  <= pll_step;
    dirf <= pll_dir;
    self <= pll_sel;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      pll_done <= 1'b1;
      rs       <= 0;
    end else begin
      case (rs)
        0: if (stf) rs <= 1;
        1: if (rmode == 1) rs <= 3;
           else begin
             pll_done <= 1'b0;
             low_left <= int'($urandom_range(lmax, 1)) - 1;
             cap_dir  <= dirf;
             cap_sel  <= self;
             rs       <= 2;
           end
        2: if (rmode != 2) begin
             if (rmode == 3 || low_left == 0) begin
               pll_done <= 1'b1;
               rs       <= 0;
               if (rmode == 0) begin
                 net[cap_sel] <= net[cap_sel] + (cap_dir ? 1 : -1);
                 rpulses      <= rpulses + 1;
               end
             end else low_left <= low_left - 1;
           end
        default: if (rmode != 1) rs <= 0;
      endcase
    end
  end

  // protocol monitor
  int mon_chk = 0, mon_fail = 0, str_cnt = 0, fin_cnt = 0, hi = 0;
  logic prev_step = 1'b0, pdir = 1'b0, pdone = 1'b1, saw_low = 1'b0;
  logic [3:0] psel = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (finish) fin_cnt++;
      if (pll_step) begin
        if (!prev_step) begin
          str_cnt++; hi = 0; saw_low = 1'b0; mon_chk++;
          if (!pdone) begin
            mon_fail++;
            $display("FAIL R5: strobe rose with done=%0d, expected 1", pdone);
          end
        end else if (pll_dir != pdir || pll_sel != psel) begin
          mon_fail++;
          $display("FAIL R4: fields moved under strobe dir %0d->%0d sel %0d->%0d", pdir, pll_dir, psel, pll_sel);
        end
        hi++;
        if (!pll_done) saw_low = 1'b1;
      end else if (prev_step) begin
        mon_chk++;
        if (hi < 2 || (!saw_low && !err)) begin
          mon_fail++;
          $display("FAIL R3: strobe width %0d saw_low %0d, expected >=2 and 1", hi, saw_low);
        end
      end
      prev_step = pll_step; pdir = pll_dir; psel = pll_sel; pdone = pll_done;
    end
  end

  task automatic chk(input bit ok, input string r, input int act, input int expv);
    vec++;
    if (!ok) begin
      miss++;
      $display("FAIL %s: got %0d expected %0d", r, act, expv);
    end
  endtask

  function automatic int tot(input int i);
    return int'($signed(totals[i*AW +: AW]));
  endfunction

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic issue(input int sel, input int steps);
    start = 1'b1; req_sel = 4'(sel); req_steps = 9'(steps);
    tick();
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 20000 && busy; n++) tick();
    tick();
  endtask

  task automatic t_reset();
    bit allz = 1'b1;
    for (int i = 0; i < NUM; i++) if (tot(i) != 0) allz = 1'b0;
    chk(!busy && !pll_step && !err && !finish, "R1 outputs idle", {busy, pll_step, err, finish}, 0);
    chk(allz, "R1 totals zero", int'(allz), 1);
  endtask

  task automatic t_run(input int sel, input int steps, input int lm);
    int s0 = str_cnt, f0 = fin_cnt;
    int mg = steps < 0 ? -steps : steps;
    lmax = lm;
    issue(sel, steps);
    chk(busy == 1'b1, "R7 busy after accept", busy, 1);
    chk(err == 1'b0, "R11 err clear after accept", err, 0);
    wait_idle();
    exp_tot[sel] += steps;
    chk(tot(sel) == exp_tot[sel], "R6 total", tot(sel), exp_tot[sel]);
    chk(net[sel] == exp_tot[sel], "R2 direction/select at PLL", net[sel], exp_tot[sel]);
    chk(str_cnt - s0 == mg, "R2 pulse count", str_cnt - s0, mg);
    chk(fin_cnt - f0 == 1, "R7 finish pulses", fin_cnt - f0, 1);
  endtask

  task automatic t_zero();
    int s0 = str_cnt;
    bit sawb = 1'b0;
    issue(1, 0);
    for (int i = 0; i < 6; i++) begin if (busy) sawb = 1'b1; tick(); end
    chk(!sawb, "R8 zero count busy", int'(sawb), 0);
    chk(str_cnt == s0, "R8 zero count strobes", str_cnt - s0, 0);
    chk(tot(1) == exp_tot[1], "R8 zero count total", tot(1), exp_tot[1]);
  endtask

  task automatic t_busy_ignore();
    int s0 = str_cnt;
    lmax = 3;
    issue(6, 4);
    for (int i = 0; i < 4; i++) tick();
    issue(7, 9);
    wait_idle();
    exp_tot[6] += 4;
    chk(tot(7) == exp_tot[7], "R8 start while busy total", tot(7), exp_tot[7]);
    chk(tot(6) == exp_tot[6], "R8 first request total", tot(6), exp_tot[6]);
    chk(str_cnt - s0 == 4, "R8 start while busy strobes", str_cnt - s0, 4);
  endtask

  task automatic t_fall_timeout();
    int t_up = -1, t_err = -1;
    rmode = 1;
    issue(2, 3);
    for (int n = 0; n < 40 && t_err < 0; n++) begin
      if (pll_step && t_up < 0) t_up = n;
      if (err) t_err = n;
      tick();
    end
    chk(t_err - t_up == 8, "R9 fall timeout edge", t_err - t_up, 8);
    chk(!busy && !pll_step, "R9 aborted", {busy, pll_step}, 0);
    for (int i = 0; i < 5; i++) tick();
    chk(err == 1'b1, "R11 err sticky", err, 1);
    chk(tot(2) == exp_tot[2], "R9 total unchanged", tot(2), exp_tot[2]);
    rmode = 0;
    for (int i = 0; i < 3; i++) tick();
  endtask

  task automatic t_rise_timeout();
    int t_dn = -1, t_err = -1;
    bit was_hi = 1'b0;
    rmode = 2; lmax = 1;
    issue(5, -2);
    for (int n = 0; n < 1200 && t_err < 0; n++) begin
      if (pll_step) was_hi = 1'b1;
      else if (was_hi && t_dn < 0) t_dn = n;
      if (err) t_err = n;
      tick();
    end
    chk(t_err - t_dn == 1024, "R10 rise timeout edge", t_err - t_dn, 1024);
    chk(!busy, "R10 busy cleared", busy, 0);
    chk(tot(5) == exp_tot[5], "R10 incomplete step not counted", tot(5), exp_tot[5]);
    rmode = 3;
    for (int i = 0; i < 4; i++) tick();
    rmode = 0;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec + mon_chk + 1, miss + mon_fail + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; req_sel = '0; req_steps = '0;
    repeat (4) @(posedge clk);
    tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_run(3, 5, 3);
    t_run(3, -7, 5);
    t_run(15, 255, 2);
    t_run(0, -255, 1);
    t_run(12, 1, 20);
    t_zero();
    t_busy_ignore();
    t_fall_timeout();
    t_run(2, 2, 4);
    t_rise_timeout();
    t_run(5, 3, 6);
    $display("== %0d vectors applied, %0d miscompares ==", vec + mon_chk, miss + mon_fail);
    $finish;
  end
endmodule